// File: doc/BRIEF.md
# Masked scalar half-to-single lane converter

This datapath block widens one half-precision (16-bit) floating-point value to single precision (32-bit) and writes the result into lane 0 of a destination vector. The value converted is bits 15:0 of the second source vector. A one-bit writemask controls the write to lane 0. When masking is enabled, it either keeps the previous lane value (merge mode) or clears the lane (zeroing mode). Bits 127:32 of the result come from the first source vector. Every bit above 127 is cleared.

The conversion is exact and needs no rounding. Subnormal inputs are normalised into single-precision normals. Signalling NaNs are quieted. The block reports invalid and denormal exception flags, and a suppress input forces both flags low. Inputs are accepted when `in_valid_i` is high. The result and flags are registered and appear one clock later, qualified by `out_valid_o`.

Top module: `half_to_single_lane0`

## Requirements
- R1: For a normal half input (exponent field 1..30), the single result keeps the sign, uses exponent field = half exponent + 112, and fraction = half fraction placed in fraction bits 22:13 with bits 12:0 zero.
- R2: Half zeros (exponent 0, fraction 0) give 0x00000000 or 0x80000000 by sign. Half infinities (exponent 31, fraction 0) give 0x7F800000 or 0xFF800000 by sign. None of these raises a flag.
- R3: A half subnormal (exponent 0, fraction nonzero) gives the exact normalised single value. The denormal flag is set and the invalid flag is clear.
- R4: A half quiet NaN (exponent 31, fraction bit 9 = 1) gives exponent 0xFF with the 10-bit payload in fraction bits 22:13. No flag is raised.
- R5: A half signalling NaN (exponent 31, fraction bit 9 = 0, fraction nonzero) gives exponent 0xFF with the payload in bits 22:13 and bit 22 forced to 1. The invalid flag is set.
- R6: When `mask_en_i` is 0, or `mask_bit_i` is 1, destination bits 31:0 take the converted value.
- R7: When `mask_en_i` is 1, `mask_bit_i` is 0 and `zero_mode_i` is 1, destination bits 31:0 are zero.
- R8: When `mask_en_i` is 1, `mask_bit_i` is 0 and `zero_mode_i` is 0, destination bits 31:0 equal `prev_lane0_i`.
- R9: Destination bits 127:32 always equal bits 127:32 of `src_a_i`, whatever the mask inputs are.
- R10: Destination bits VLEN-1:128 are always zero.
- R11: When `sae_i` is 1, both flag outputs are 0 and the data result is the same as without suppression.
- R12: The flags are computed from the source element even when the mask blocks the write to lane 0.
- R13: Inputs sampled on a clock edge with `in_valid_i` high appear at the outputs after that edge with `out_valid_o` high. After an edge with `in_valid_i` low, `out_valid_o` is 0 and the data and flags keep their previous values.
- R14: While `rst_ni` is low, `out_valid_o`, `dest_o`, `invalid_o` and `denormal_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Inputs are valid this cycle |
| src_a_i | input | VLEN | First source; supplies bits 127:32 |
| src_b_i | input | VLEN | Second source; bits 15:0 are converted |
| prev_lane0_i | input | 32 | Previous destination lane 0, used in merge mode |
| mask_en_i | input | 1 | Writemask active |
| mask_bit_i | input | 1 | Writemask bit for lane 0 |
| zero_mode_i | input | 1 | 1 = zeroing, 0 = merging when the write is blocked |
| sae_i | input | 1 | Suppress exception flags |
| out_valid_o | output | 1 | Registered result valid |
| dest_o | output | VLEN | Destination vector |
| invalid_o | output | 1 | Invalid flag (signalling NaN input) |
| denormal_o | output | 1 | Denormal flag (subnormal input) |

## Verification
The conversion is tried with one value from every input class: the smallest, largest and typical normals, both signed zeros and infinities, subnormals with the leading one at the top and at the bottom bit, and quiet and signalling NaNs. These separate the rebias, normalisation and quieting paths. Each of the three mask outcomes is applied to a signalling NaN and to a subnormal. This shows that the flags follow the source and not the write, and that merge mode is distinguished from zeroing. Suppression is crossed with flag-raising inputs. Random vectors, with every upper bit of both sources set, show that the copy of bits 127:32 and the clearing above bit 127 do not depend on the data. Idle cycles placed between accepted inputs show that the outputs hold their values.

// File: rtl/h2s_pkg.sv
package h2s_pkg;
  typedef struct packed {
    logic       sign;
    logic [4:0] exp;
    logic [9:0] frac;
  } half_t;

  typedef struct packed {
    logic invalid;
    logic denormal;
  } exc_t;

  localparam int unsigned HalfW    = 16;
  localparam int unsigned SingleW  = 32;
  localparam int unsigned SliceW   = 128;
  localparam logic [7:0]  RebiasC  = 8'd112;  // 127 - 15
endpackage

// File: rtl/h2s_convert.sv
module h2s_convert
  import h2s_pkg::*;
(
  input  half_t       half_i,
  output logic [31:0] single_o,
  output exc_t        exc_o
);
  logic [3:0] lz;
  logic       seen;
  logic [9:0] norm_frac;
  logic [7:0] sub_exp;

  // leading-zero count over the 10-bit fraction
  always_comb begin
    lz   = 4'd0;
    seen = 1'b0;
    for (int i = 9; i >= 0; i--) begin
      if (!seen) begin
        if (half_i.frac[i]) seen = 1'b1;
        else                lz   = lz + 4'd1;
      end
    end
  end

  assign norm_frac = half_i.frac << (lz + 4'd1);
  assign sub_exp   = RebiasC - {4'd0, lz};

  always_comb begin
    exc_o = '0;
    if (half_i.exp == 5'd0) begin
      if (half_i.frac == 10'd0) begin
        single_o = {half_i.sign, 31'd0};
      end else begin
        single_o       = {half_i.sign, sub_exp, norm_frac, 13'd0};
        exc_o.denormal = 1'b1;
      end
    end else if (half_i.exp == 5'h1f) begin
      if (half_i.frac == 10'd0) begin
        single_o = {half_i.sign, 8'hff, 23'd0};
      end else begin
        single_o      = {half_i.sign, 8'hff, 1'b1, half_i.frac[8:0], 13'd0};
        exc_o.invalid = ~half_i.frac[9];
      end
    end else begin
      single_o = {half_i.sign, {3'd0, half_i.exp} + RebiasC, half_i.frac, 13'd0};
    end
  end

  // R3
  always_comb begin
    if (exc_o.denormal) begin
      subnorm_range_chk: assert (single_o[30:23] >= 8'd103 && single_o[30:23] <= 8'd112);
    end
  end
endmodule

// File: rtl/h2s_lane_pack.sv
module h2s_lane_pack #(
  parameter int unsigned VLEN = 512
) (
  input  logic [VLEN-1:0] src_a_i,
  input  logic [31:0]     conv_i,
  input  logic [31:0]     prev_i,
  input  logic            mask_en_i,
  input  logic            mask_bit_i,
  input  logic            zero_mode_i,
  output logic [VLEN-1:0] dest_o
);
  localparam int unsigned SliceW = h2s_pkg::SliceW;
  logic        wr_en;
  logic [31:0] lane0;

  assign wr_en = ~mask_en_i | mask_bit_i;

  always_comb begin
    if (wr_en)            lane0 = conv_i;
    else if (zero_mode_i) lane0 = 32'd0;
    else                  lane0 = prev_i;
  end

  assign dest_o[31:0]       = lane0;
  assign dest_o[SliceW-1:32] = src_a_i[SliceW-1:32];

  generate
    if (VLEN > SliceW) begin : g_upper
      assign dest_o[VLEN-1:SliceW] = '0;
    end
  endgenerate
endmodule

// File: rtl/half_to_single_lane0.sv
module half_to_single_lane0
  import h2s_pkg::*;
#(
  parameter int unsigned VLEN = 512
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [VLEN-1:0] src_a_i,
  input  logic [VLEN-1:0] src_b_i,
  input  logic [31:0]     prev_lane0_i,
  input  logic            mask_en_i,
  input  logic            mask_bit_i,
  input  logic            zero_mode_i,
  input  logic            sae_i,
  output logic            out_valid_o,
  output logic [VLEN-1:0] dest_o,
  output logic            invalid_o,
  output logic            denormal_o
);
  half_t           half_in;
  logic [31:0]     conv;
  exc_t            exc_raw;
  logic [VLEN-1:0] dest_d;

  assign half_in = half_t'(src_b_i[HalfW-1:0]);

  h2s_convert u_convert (
    .half_i  (half_in),
    .single_o(conv),
    .exc_o   (exc_raw)
  );

  h2s_lane_pack #(.VLEN(VLEN)) u_pack (
    .src_a_i    (src_a_i),
    .conv_i     (conv),
    .prev_i     (prev_lane0_i),
    .mask_en_i  (mask_en_i),
    .mask_bit_i (mask_bit_i),
    .zero_mode_i(zero_mode_i),
    .dest_o     (dest_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      dest_o      <= '0;
      invalid_o   <= 1'b0;
      denormal_o  <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        dest_o     <= dest_d;
        invalid_o  <= exc_raw.invalid & ~sae_i;
        denormal_o <= exc_raw.denormal & ~sae_i;
      end
    end
  end

  // R9
  mid_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> dest_o[SliceW-1:32] == $past(src_a_i[SliceW-1:32]));

  // R7
  zero_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && $past(mask_en_i && !mask_bit_i && zero_mode_i) |-> dest_o[31:0] == 32'd0);

  // R8
  merge_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && $past(mask_en_i && !mask_bit_i && !zero_mode_i)
      |-> dest_o[31:0] == $past(prev_lane0_i));

  // R11
  sae_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && $past(sae_i) |-> !invalid_o && !denormal_o);

  // R13
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o && $stable(dest_o) && $stable(invalid_o));

  generate
    if (VLEN > SliceW) begin : g_upper_chk
      // R10
      upper_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dest_o[VLEN-1:SliceW] == '0);
    end
  endgenerate
endmodule

// File: tb/half_to_single_lane0_bench.sv
module half_to_single_lane0_bench;
  localparam int CLK_P = 10;
  localparam int VLEN  = 512;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [VLEN-1:0] src_a = '0;
  logic [VLEN-1:0] src_b = '0;
  logic [31:0]     prev_l0 = '0;
  logic            m_en = 1'b0, m_bit = 1'b0, z_mode = 1'b0, sae = 1'b0;
  logic            out_valid;
  logic [VLEN-1:0] dest;
  logic            inv, den;

  int checks = 0;
  int failures = 0;

  logic [VLEN-1:0] exp_dest = '0;
  logic            exp_inv = 1'b0, exp_den = 1'b0, exp_valid = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  half_to_single_lane0 #(.VLEN(VLEN)) u_half_to_single_lane0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid),
    .src_a_i(src_a), .src_b_i(src_b), .prev_lane0_i(prev_l0),
    .mask_en_i(m_en), .mask_bit_i(m_bit), .zero_mode_i(z_mode), .sae_i(sae),
    .out_valid_o(out_valid), .dest_o(dest), .invalid_o(inv), .denormal_o(den)
  );

  // Behavioural reference for the half-to-single widening
  function automatic void ref_conv(input logic [15:0] h, output logic [31:0] s,
                                   output logic fi, output logic fd);
    int sg, e, f, m, ex;
    sg = int'(h[15]); e = int'(h[14:10]); f = int'(h[9:0]);
    fi = 1'b0; fd = 1'b0;
    if (e == 0 && f == 0) s = {h[15], 31'd0};
    else if (e == 0) begin
      m = f; ex = -14;
      while (m < 1024) begin m = m * 2; ex = ex - 1; end
      s = {h[15], 8'(ex + 127), 23'((m - 1024) * 8192)};
      fd = 1'b1;
    end else if (e == 31 && f == 0) s = {h[15], 8'hff, 23'd0};
    else if (e == 31) begin
      if (f < 512) fi = 1'b1;
      s = {h[15], 8'hff, 23'((f | 512) * 8192)};
    end else s = {h[15], 8'(e - 15 + 127), 23'(f * 8192)};
    if (sg < 0) s = '0;
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (out_valid !== exp_valid || dest !== exp_dest || inv !== exp_inv || den !== exp_den) begin
      failures++;
      $display("FAIL %s: valid=%b dest=%h inv=%b den=%b expected valid=%b dest=%h inv=%b den=%b",
               tag, out_valid, dest, inv, den, exp_valid, exp_dest, exp_inv, exp_den);
    end
  endtask

  // Drive at negedge, check one negedge later (one register in the path)
  task automatic step(input logic v, input logic [VLEN-1:0] a, input logic [VLEN-1:0] b,
                      input logic [31:0] old, input logic me, input logic mb,
                      input logic zm, input logic su, input string tag);
    logic [31:0] s;
    logic fi, fd;
    in_valid = v; src_a = a; src_b = b; prev_l0 = old;
    m_en = me; m_bit = mb; z_mode = zm; sae = su;
    exp_valid = v;
    if (v) begin
      ref_conv(b[15:0], s, fi, fd);
      exp_dest = '0;
      exp_dest[127:32] = a[127:32];
      if (!me || mb) exp_dest[31:0] = s;
      else if (zm)   exp_dest[31:0] = 32'd0;
      else           exp_dest[31:0] = old;
      exp_inv = fi && !su;
      exp_den = fd && !su;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic conv(input logic [15:0] h, input string tag);
    logic [VLEN-1:0] a, b;
    a = {VLEN/32{32'hA5A5_5A5A}};
    b = {{(VLEN-16){1'b1}}, h};
    step(1'b1, a, b, 32'h1234_5678, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #(CLK_P * 100000);
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [VLEN-1:0] ones;
    ones = '1;
    @(negedge clk);
    exp_valid = 1'b0; exp_dest = '0; exp_inv = 1'b0; exp_den = 1'b0;
    src_a = ones; src_b = ones; in_valid = 1'b1;
    @(negedge clk);
    compare("R14 reset");
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    compare("R14 after release");

    // R1 normals
    conv(16'h3C00, "R1 one");
    conv(16'hC500, "R1 neg five");
    conv(16'h7BFF, "R1 max normal");
    conv(16'h0400, "R1 min normal");
    // R2 zeros, infinities
    conv(16'h0000, "R2 +zero");
    conv(16'h8000, "R2 -zero");
    conv(16'h7C00, "R2 +inf");
    conv(16'hFC00, "R2 -inf");
    // R3 subnormals
    conv(16'h0001, "R3 min sub");
    conv(16'h83FF, "R3 max sub");
    conv(16'h0155, "R3 mid sub");
    // R4/R5 NaNs
    conv(16'h7E01, "R4 qnan");
    conv(16'hFFFF, "R4 qnan all");
    conv(16'h7C01, "R5 snan");
    conv(16'hFD55, "R5 snan neg");

    // R6 mask allows write
    step(1'b1, ones, {ones[VLEN-1:16], 16'h4248}, 32'hDEAD_BEEF, 1'b1, 1'b1, 1'b1, 1'b0, "R6 mask bit set");
    step(1'b1, ones, {ones[VLEN-1:16], 16'h4248}, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b1, 1'b0, "R6 mask off");
    // R7 zeroing, R12 flags still raised
    step(1'b1, ones, {ones[VLEN-1:16], 16'h7C01}, 32'hDEAD_BEEF, 1'b1, 1'b0, 1'b1, 1'b0, "R7 R12 zeroing snan");
    // R8 merge, R12 denormal still raised
    step(1'b1, ones, {ones[VLEN-1:16], 16'h0003}, 32'hDEAD_BEEF, 1'b1, 1'b0, 1'b0, 1'b0, "R8 R12 merge sub");
    step(1'b1, '0, '0, 32'hCAFE_F00D, 1'b1, 1'b0, 1'b0, 1'b0, "R8 merge zero src");
    // R11 suppression
    step(1'b1, ones, {ones[VLEN-1:16], 16'h7C01}, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, "R11 sae snan");
    step(1'b1, ones, {ones[VLEN-1:16], 16'h0001}, 32'h0, 1'b1, 1'b1, 1'b0, 1'b1, "R11 sae sub");
    // R13 idle cycles hold outputs, then back-to-back
    step(1'b1, ones, {ones[VLEN-1:16], 16'h0200}, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R13 load");
    step(1'b0, '0, '0, 32'h0, 1'b1, 1'b0, 1'b1, 1'b1, "R13 idle hold");
    step(1'b0, ones, ones, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R13 idle hold 2");
    step(1'b1, ones, {ones[VLEN-1:16], 16'h3555}, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R13 resume");

    // R9/R10 random data and masks
    for (int i = 0; i < 300; i++) begin
      logic [VLEN-1:0] a, b;
      for (int w = 0; w < VLEN/32; w++) begin
        a[w*32 +: 32] = $urandom;
        b[w*32 +: 32] = $urandom;
      end
      if (i % 3 == 0) begin a = a | ~('1 >> (VLEN-128)) ; b = ones; b[15:0] = 16'($urandom); end
      step(($urandom % 5) != 0, a, b, $urandom, 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), "R9 R10 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule